// File: doc/BRIEF.md
# Compacted-Layout State Restore Sequencer

This block drives the restore of a set of architectural state components from a save area in memory. A header check upstream supplies three masks and a form bit. The masks are the requested set, the saved set and the format set, and the form bit chooses between the standard and the compacted layout. On a start strobe the sequencer latches these inputs. It then visits each component in a fixed order and issues, for each one, a load command, an initialize command or nothing at all. Each command carries a kind, a component index and a byte offset into the save area, and it is held on a valid/ready interface until the consumer accepts it.

Per-component byte sizes and fixed standard offsets are held in a small table that is written through a dedicated port before use. In the standard layout every component sits at its table offset. In the compacted layout, components from index 2 upward are packed one after another, starting at byte 576. The block tracks which components are in use and, at the end of a sequence, which ones count as modified. It owns the control/status word of the vector-register component. It checks that word against a reserved-bit mask when the word is loaded, and ends the sequence with a fault strobe if the check fails.

Top module: `cstate_restore_seq`

## Requirements
- R1: After start, components are visited in this order: component 0, then a control-word step, then component 1, then components 2 to NCOMP-1 in ascending order. Each accepted command appears in that order.
- R2: Command kinds are encoded as load = 0, initialize = 1 and control-word load = 2. A load is issued for a component that is requested and saved. An initialize is issued for a component that is requested and not saved. In the standard layout, every load uses the table offset of its component, and every initialize carries offset 0.
- R3: In the compacted layout, loads of components 2 and up use a running offset that starts at 576. The offset grows by the table size of component i after component i is visited, whenever format bit i is set, whether that component was loaded, initialized or skipped.
- R4: In the standard layout, a control-word load (component index 1, offset CW_OFF = 24) is issued whenever requested bit 1 or requested bit 2 is set.
- R5: In the compacted layout, a control-word load is issued only when component 1 is loaded. An initialize of component 1 sets the control word to 0x1F80. A requested component whose format bit is clear is initialized.
- R6: When an accepted control-word load carries data with any bit set that is also set in the reserved mask, a fault strobe follows. The control word, the in-use bits and the modified bits stay unchanged, no further command is issued, and busy drops.
- R7: An accepted load sets the component's in-use bit and an accepted initialize clears it. A component that is not requested issues no command and keeps its in-use bit.
- R8: On completion, done pulses for one cycle and the modified bitmap becomes the bitwise NOT of the requested mask.
- R9: Visiting a component with no command takes one cycle. A command stays valid with stable fields until ready is seen. No command is valid while the block is idle.
- R10: After reset the block is idle, no command is valid, the control word reads 0x1F80, and the in-use and modified bitmaps are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a sequence (ignored while busy) |
| compact | input | 1 | 1 selects the compacted layout |
| req_mask | input | NCOMP | Requested components |
| saved_mask | input | NCOMP | Components present with saved data |
| fmt_mask | input | NCOMP | Components present in the compacted format |
| rsv_mask | input | CW_W | Reserved control-word bits |
| tbl_we | input | 1 | Table write enable |
| tbl_idx | input | IDX_W | Table entry to write |
| tbl_size | input | OFF_W | Component size in bytes |
| tbl_off | input | OFF_W | Standard-layout offset in bytes |
| cmd_valid | output | 1 | Command valid |
| cmd_ready | input | 1 | Command accepted by consumer |
| cmd_kind | output | 2 | 0 load, 1 initialize, 2 control-word load |
| cmd_comp | output | IDX_W | Component index |
| cmd_off | output | OFF_W | Byte offset in the save area |
| cw_rdata | input | CW_W | Control-word data, valid when a control-word load is accepted |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion strobe |
| fault | output | 1 | One-cycle reserved-bit fault strobe |
| ctrl_word | output | CW_W | Current control word |
| inuse | output | NCOMP | In-use bitmap |
| modified | output | NCOMP | Modified bitmap |

## Verification
Commands are combinational from the sequencer state. Each one is compared on the falling edge of the cycle in which valid and ready are both high, against a queue that the driver filled in visiting order. In-use and control-word updates land on the rising edge that accepts the command. The done or fault strobe appears in the cycle after the last advance or after the offending handshake, so the bench samples the bitmaps and the control word at the falling edge on which it first sees either strobe. Ready is stalled in a pseudo-random pattern so that held commands are also exercised.

// File: rtl/cstate_pkg.sv
`timescale 1ns/1ps
package cstate_pkg;
   typedef enum logic [1:0] {
      CMD_LOAD   = 2'd0,
      CMD_INIT   = 2'd1,
      CMD_CWLOAD = 2'd2,
      CMD_NONE   = 2'd3
   } cmd_kind_e;
endpackage

// File: rtl/cstate_mask_calc.sv
`timescale 1ns/1ps
module cstate_mask_calc #(
   parameter int NCOMP = 8
) (
   input  logic             compact,
   input  logic [NCOMP-1:0] req_mask,
   input  logic [NCOMP-1:0] saved_mask,
   input  logic [NCOMP-1:0] fmt_mask,
   output logic [NCOMP-1:0] load_mask,
   output logic [NCOMP-1:0] init_mask
);
   for (genvar i = 0; i < NCOMP; i++) begin : g_bit
      logic in_fmt;
      assign in_fmt       = compact ? fmt_mask[i] : 1'b1;
      assign load_mask[i] = req_mask[i] & saved_mask[i] & in_fmt;
      assign init_mask[i] = req_mask[i] & (~saved_mask[i] | ~in_fmt);
   end
endmodule

// File: rtl/cstate_layout_tbl.sv
`timescale 1ns/1ps
module cstate_layout_tbl #(
   parameter int NCOMP = 8,
   parameter int OFF_W = 16,
   localparam int IDX_W = $clog2(NCOMP)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] widx,
   input  logic [OFF_W-1:0] wsize,
   input  logic [OFF_W-1:0] woff,
   input  logic [IDX_W-1:0] ridx,
   output logic [OFF_W-1:0] rsize,
   output logic [OFF_W-1:0] roff
);
   logic [OFF_W-1:0] size_q [NCOMP];
   logic [OFF_W-1:0] off_q  [NCOMP];

   for (genvar i = 0; i < NCOMP; i++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            size_q[i] <= '0;
            off_q[i]  <= '0;
         end else if (we && widx == IDX_W'(i)) begin
            size_q[i] <= wsize;
            off_q[i]  <= woff;
         end
      end
   end

   assign rsize = size_q[ridx];
   assign roff  = off_q[ridx];
endmodule

// File: rtl/cstate_offset_acc.sv
`timescale 1ns/1ps
module cstate_offset_acc #(
   parameter int OFF_W    = 16,
   parameter int BASE_OFF = 576
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             add_en,
   input  logic [OFF_W-1:0] add_val,
   output logic [OFF_W-1:0] run_off
);
   if (BASE_OFF >= (1 << OFF_W)) begin : g_chk
      $error("BASE_OFF does not fit in OFF_W bits");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      run_off <= OFF_W'(BASE_OFF);
      else if (clear)  run_off <= OFF_W'(BASE_OFF);
      else if (add_en) run_off <= run_off + add_val;
   end
endmodule

// File: rtl/cstate_restore_seq.sv
`timescale 1ns/1ps
module cstate_restore_seq #(
   parameter int NCOMP    = 8,
   parameter int OFF_W    = 16,
   parameter int CW_W     = 32,
   parameter int CW_OFF   = 24,
   parameter int BASE_OFF = 576,
   parameter logic [CW_W-1:0] CW_INIT = CW_W'(32'h1F80),
   localparam int IDX_W   = $clog2(NCOMP),
   localparam int SLOT_W  = $clog2(NCOMP + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             compact,
   input  logic [NCOMP-1:0] req_mask,
   input  logic [NCOMP-1:0] saved_mask,
   input  logic [NCOMP-1:0] fmt_mask,
   input  logic [CW_W-1:0]  rsv_mask,
   input  logic             tbl_we,
   input  logic [IDX_W-1:0] tbl_idx,
   input  logic [OFF_W-1:0] tbl_size,
   input  logic [OFF_W-1:0] tbl_off,
   output logic             cmd_valid,
   input  logic             cmd_ready,
   output logic [1:0]       cmd_kind,
   output logic [IDX_W-1:0] cmd_comp,
   output logic [OFF_W-1:0] cmd_off,
   input  logic [CW_W-1:0]  cw_rdata,
   output logic             busy,
   output logic             done,
   output logic             fault,
   output logic [CW_W-1:0]  ctrl_word,
   output logic [NCOMP-1:0] inuse,
   output logic [NCOMP-1:0] modified
);
   import cstate_pkg::*;

   if (NCOMP < 3 || NCOMP > 63) begin : g_bad_ncomp
      $error("NCOMP must lie between 3 and 63");
   end
   if (CW_OFF >= (1 << OFF_W)) begin : g_bad_cwoff
      $error("CW_OFF does not fit in OFF_W bits");
   end

   localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NCOMP);

   // latched sequence context
   logic             busy_q, done_q, fault_q, compact_q;
   logic [SLOT_W-1:0] slot_q;
   logic [NCOMP-1:0] req_q, load_q, init_q, fmt_q;
   logic [NCOMP-1:0] load_m, init_m;
   logic [NCOMP-1:0] inuse_q, modified_q;
   logic [CW_W-1:0]  ctrl_q;

   cstate_mask_calc #(.NCOMP(NCOMP)) u_masks (
      .compact   (compact),
      .req_mask  (req_mask),
      .saved_mask(saved_mask),
      .fmt_mask  (fmt_mask),
      .load_mask (load_m),
      .init_mask (init_m)
   );

   // slot to component mapping: slot 1 is the control-word step
   logic             is_cw;
   logic [IDX_W-1:0] cur_comp;
   assign is_cw    = (slot_q == SLOT_W'(1));
   assign cur_comp = (slot_q > SLOT_W'(1)) ? IDX_W'(slot_q - SLOT_W'(1)) : IDX_W'(slot_q);

   logic [OFF_W-1:0] t_size, t_off, run_off;

   cstate_layout_tbl #(.NCOMP(NCOMP), .OFF_W(OFF_W)) u_tbl (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (tbl_we),
      .widx (tbl_idx),
      .wsize(tbl_size),
      .woff (tbl_off),
      .ridx (cur_comp),
      .rsize(t_size),
      .roff (t_off)
   );

   // action decode for the current slot
   cmd_kind_e act;
   logic      cw_wanted;
   always_comb begin
      cw_wanted = compact_q ? load_q[1] : (req_q[1] | req_q[2]);
      act       = CMD_NONE;
      if (is_cw) begin
         if (cw_wanted) act = CMD_CWLOAD;
      end else if (load_q[cur_comp]) begin
         act = CMD_LOAD;
      end else if (init_q[cur_comp]) begin
         act = CMD_INIT;
      end
   end

   logic packed_slot;
   assign packed_slot = compact_q && !is_cw && (cur_comp > IDX_W'(1));

   always_comb begin
      unique case (act)
         CMD_LOAD:   cmd_off = packed_slot ? run_off : t_off;
         CMD_CWLOAD: cmd_off = OFF_W'(CW_OFF);
         default:    cmd_off = '0;
      endcase
   end

   assign cmd_valid = busy_q && (act != CMD_NONE);
   assign cmd_kind  = act;
   assign cmd_comp  = cur_comp;

   logic hs, adv, cw_bad, launch;
   assign hs     = cmd_valid && cmd_ready;
   assign adv    = busy_q && (!cmd_valid || cmd_ready);
   assign cw_bad = hs && (act == CMD_CWLOAD) && ((cw_rdata & rsv_mask) != '0);
   assign launch = start && !busy_q;

   cstate_offset_acc #(.OFF_W(OFF_W), .BASE_OFF(BASE_OFF)) u_acc (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (launch),
      .add_en (adv && packed_slot && fmt_q[cur_comp]),
      .add_val(t_size),
      .run_off(run_off)
   );

   // sequencing
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q     <= 1'b0;
         done_q     <= 1'b0;
         fault_q    <= 1'b0;
         compact_q  <= 1'b0;
         slot_q     <= '0;
         req_q      <= '0;
         load_q     <= '0;
         init_q     <= '0;
         fmt_q      <= '0;
         modified_q <= '0;
      end else begin
         done_q  <= 1'b0;
         fault_q <= 1'b0;
         if (launch) begin
            busy_q    <= 1'b1;
            slot_q    <= '0;
            req_q     <= req_mask;
            load_q    <= load_m;
            init_q    <= init_m;
            fmt_q     <= fmt_mask;
            compact_q <= compact;
         end else if (cw_bad) begin
            busy_q  <= 1'b0;
            fault_q <= 1'b1;
         end else if (adv) begin
            if (slot_q == LAST_SLOT) begin
               busy_q     <= 1'b0;
               done_q     <= 1'b1;
               modified_q <= ~req_q;
            end else begin
               slot_q <= slot_q + SLOT_W'(1);
            end
         end
      end
   end

   // tracking and control word
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         inuse_q <= '0;
         ctrl_q  <= CW_INIT;
      end else if (hs && !cw_bad) begin
         unique case (act)
            CMD_LOAD: inuse_q[cur_comp] <= 1'b1;
            CMD_INIT: begin
               inuse_q[cur_comp] <= 1'b0;
               if (compact_q && cur_comp == IDX_W'(1)) ctrl_q <= CW_INIT;
            end
            CMD_CWLOAD: ctrl_q <= cw_rdata;
            default: ;
         endcase
      end
   end

   assign busy      = busy_q;
   assign done      = done_q;
   assign fault     = fault_q;
   assign ctrl_word = ctrl_q;
   assign inuse     = inuse_q;
   assign modified  = modified_q;
endmodule

// File: rtl/cstate_restore_chk.sv
`timescale 1ns/1ps
module cstate_restore_chk #(
   parameter int NCOMP  = 8,
   parameter int IDX_W  = 3,
   parameter int OFF_W  = 16,
   parameter int CW_W   = 32,
   parameter int CW_OFF = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic             busy,
   input logic             done,
   input logic             fault,
   input logic             cmd_valid,
   input logic             cmd_ready,
   input logic [1:0]       cmd_kind,
   input logic [IDX_W-1:0] cmd_comp,
   input logic [OFF_W-1:0] cmd_off,
   input logic [CW_W-1:0]  ctrl_word,
   input logic [NCOMP-1:0] inuse,
   input logic [NCOMP-1:0] modified
);
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_kind) && $stable(cmd_comp) && $stable(cmd_off));

   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !cmd_valid);

   p_done_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !fault && !busy);

   p_mod_only_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(modified) |-> done);

   p_fault_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> $past(cmd_valid && cmd_ready && cmd_kind == 2'd2) && $stable(ctrl_word)
                && $stable(inuse) && !busy);

   p_inuse_by_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(inuse) |-> $past(cmd_valid && cmd_ready && cmd_kind != 2'd2));

   p_cw_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_kind == 2'd2 |-> cmd_comp == IDX_W'(1) && cmd_off == OFF_W'(CW_OFF));
endmodule

bind cstate_restore_seq cstate_restore_chk #(
   .NCOMP(NCOMP), .IDX_W(IDX_W), .OFF_W(OFF_W), .CW_W(CW_W), .CW_OFF(CW_OFF)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy     (busy),
   .done     (done),
   .fault    (fault),
   .cmd_valid(cmd_valid),
   .cmd_ready(cmd_ready),
   .cmd_kind (cmd_kind),
   .cmd_comp (cmd_comp),
   .cmd_off  (cmd_off),
   .ctrl_word(ctrl_word),
   .inuse    (inuse),
   .modified (modified)
);

// File: tb/cstate_restore_seq_test.sv
`timescale 1ns/1ps
module cstate_restore_seq_test;
   localparam int N = 8;

   typedef struct packed {
      logic [1:0]  k;
      logic [2:0]  c;
      logic [15:0] o;
   } exp_cmd_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0, compact = 1'b0;
   logic [N-1:0] req_mask = '0, saved_mask = '0, fmt_mask = '0;
   logic [31:0] rsv_mask = 32'hFFFF_0000;
   logic        tbl_we = 1'b0;
   logic [2:0]  tbl_idx = '0;
   logic [15:0] tbl_size = '0, tbl_off = '0;
   logic        cmd_valid, cmd_ready = 1'b0;
   logic [1:0]  cmd_kind;
   logic [2:0]  cmd_comp;
   logic [15:0] cmd_off;
   logic [31:0] cw_rdata = '0;
   logic        busy, done, fault;
   logic [31:0] ctrl_word;
   logic [N-1:0] inuse, modified;

   int checks = 0, failures = 0;
   string cur_tag = "R1";
   exp_cmd_t exp_q[$];

   logic [15:0] m_size [N];
   logic [15:0] m_off  [N];
   logic [N-1:0] m_inuse = '0, m_mod = '0;
   logic [31:0]  m_ctrl = 32'h1F80;

   always #10 clk = ~clk;   // 50 MHz

   cstate_restore_seq uut (
      .clk(clk), .rst_n(rst_n), .start(start), .compact(compact),
      .req_mask(req_mask), .saved_mask(saved_mask), .fmt_mask(fmt_mask),
      .rsv_mask(rsv_mask), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
      .tbl_size(tbl_size), .tbl_off(tbl_off), .cmd_valid(cmd_valid),
      .cmd_ready(cmd_ready), .cmd_kind(cmd_kind), .cmd_comp(cmd_comp),
      .cmd_off(cmd_off), .cw_rdata(cw_rdata), .busy(busy), .done(done),
      .fault(fault), .ctrl_word(ctrl_word), .inuse(inuse), .modified(modified)
   );

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // pseudo-random ready with stalls
   logic [4:0] lfsr = 5'h13;
   always @(posedge clk) begin
      #2;
      lfsr      = {lfsr[3:0], lfsr[4] ^ lfsr[2]};
      cmd_ready = lfsr[0] | lfsr[3];
   end

   // monitor: compare every accepted command against the queue
   always @(negedge clk) begin
      if (rst_n && cmd_valid && cmd_ready) begin
         if (exp_q.size() == 0) begin
            chk(cur_tag, "unexpected command (R9)", {cmd_kind, cmd_comp, cmd_off}, 32'h0);
         end else begin
            exp_cmd_t e;
            e = exp_q.pop_front();
            chk(cur_tag, "cmd kind/comp/offset (R1 order)", {cmd_kind, cmd_comp, cmd_off}, {e.k, e.c, e.o});
         end
      end
   end

   task automatic push(input logic [1:0] k, input int c, input logic [15:0] o);
      exp_cmd_t e;
      e.k = k; e.c = 3'(c); e.o = o;
      exp_q.push_back(e);
   endtask

   // driver: builds the expected commands and final state, then runs
   task automatic run_case(input string tag, input logic cmp, input logic [N-1:0] rq,
                           input logic [N-1:0] sv, input logic [N-1:0] fm, input logic [31:0] cw);
      logic [N-1:0] ld, in;
      logic [15:0] run;
      logic exp_fault;
      bit stop;
      int waitc;
      cur_tag = tag;
      exp_fault = 1'b0;
      stop = 0;
      for (int i = 0; i < N; i++) begin
         logic f;
         f = cmp ? fm[i] : 1'b1;
         ld[i] = rq[i] & sv[i] & f;
         in[i] = rq[i] & (~sv[i] | ~f);
      end
      run = 16'd576;
      for (int s = 0; s <= N && !stop; s++) begin
         if (s == 1) begin
            if (cmp ? ld[1] : (rq[1] | rq[2])) begin
               push(2'd2, 1, 16'd24);
               if ((cw & rsv_mask) != 0) begin exp_fault = 1'b1; stop = 1; end
               else m_ctrl = cw;
            end
         end else begin
            int c;
            c = (s == 0) ? 0 : s - 1;
            if (ld[c]) begin
               push(2'd0, c, (cmp && c >= 2) ? run : m_off[c]);
               m_inuse[c] = 1'b1;
            end else if (in[c]) begin
               push(2'd1, c, 16'd0);
               m_inuse[c] = 1'b0;
               if (cmp && c == 1) m_ctrl = 32'h1F80;
            end
            if (cmp && c >= 2 && fm[c]) run = run + m_size[c];
         end
      end
      if (!exp_fault) m_mod = ~rq;

      @(negedge clk);
      compact = cmp; req_mask = rq; saved_mask = sv; fmt_mask = fm; cw_rdata = cw;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      waitc = 0;
      while (!done && !fault && waitc < 500) begin
         @(negedge clk);
         waitc++;
      end
      chk(tag, "fault strobe (R6)", {31'd0, fault}, {31'd0, exp_fault});
      chk(tag, "done strobe (R8)", {31'd0, done}, {31'd0, ~exp_fault});
      chk(tag, "commands left in queue (R9)", exp_q.size(), 0);
      chk(tag, "inuse (R7)", {24'd0, inuse}, {24'd0, m_inuse});
      chk(tag, "modified (R8)", {24'd0, modified}, {24'd0, m_mod});
      chk(tag, "ctrl_word (R5)", ctrl_word, m_ctrl);
      chk(tag, "busy after end", {31'd0, busy}, 32'd0);
      exp_q.delete();
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk("R10", "busy", {31'd0, busy}, 32'd0);
      chk("R10", "cmd_valid", {31'd0, cmd_valid}, 32'd0);
      chk("R10", "ctrl_word", ctrl_word, 32'h1F80);
      chk("R10", "inuse", {24'd0, inuse}, 32'd0);
      chk("R10", "modified", {24'd0, modified}, 32'd0);

      // program table: sizes and standard offsets
      for (int i = 0; i < N; i++) begin
         m_size[i] = (i < 2) ? 16'd0 : 16'(64 + 16 * i);
         m_off[i]  = (i == 0) ? 16'd0 : (i == 1) ? 16'd160 : 16'(576 + 256 * i);
         tbl_we = 1'b1; tbl_idx = 3'(i); tbl_size = m_size[i]; tbl_off = m_off[i];
         @(negedge clk);
      end
      tbl_we = 1'b0;

      run_case("R2", 1'b0, 8'hFF, 8'hA5, 8'h00, 32'h0000_1F00);   // standard mix
      run_case("R4", 1'b0, 8'h04, 8'h04, 8'h00, 32'h0000_1234);   // bit2 only pulls control word
      run_case("R3", 1'b1, 8'hFF, 8'hB3, 8'hB7, 32'h0000_0040);   // compacted, forced inits
      run_case("R5", 1'b1, 8'h02, 8'h00, 8'h02, 32'h0000_0000);   // compact init of comp 1
      run_case("R3", 1'b1, 8'h81, 8'hFF, 8'hFD, 32'h0000_0000);   // unrequested fmt comps advance
      run_case("R11", 1'b1, 8'h3C, 8'h3C, 8'h24, 32'h0000_0000);  // requested but outside format: R5
      run_case("R6", 1'b0, 8'hFF, 8'hFF, 8'h00, 32'h0001_0000);   // reserved bit fault
      run_case("R7", 1'b0, 8'h00, 8'hFF, 8'h00, 32'h0000_0000);   // nothing requested
      run_case("R1", 1'b0, 8'hF0, 8'h50, 8'h00, 32'h0000_0000);   // upper components only

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule